// File: doc/BRIEF.md
# Serial Programming Instruction Receiver

This block is the target-side end of a synchronous serial programming link. A host drives a serial clock and a data line and sends instructions that are always exactly four bytes long. The block brings the serial clock, serial data and the active-high target reset into the system clock domain. It assembles the four bytes and returns a response byte on the serial output while each byte is being received. Each complete instruction goes to the memory-side logic as an opcode, two address bytes and a data byte, marked by a one-cycle valid strobe.

The link does nothing until the host sends the programming-enable instruction. That instruction has 0xAC as its first byte and 0x53 as its second byte. The host checks byte alignment by watching the second byte come back while it shifts in the third byte. The link has no timeout. If it loses byte alignment, the only way back is a pulse on the target reset, which restarts framing from the first byte. Two further instructions answer in the fourth byte: a read returns a byte from memory, and a status poll returns a busy flag.

Top module: `prog_serial_if`

## Requirements
- R1: Serial data is sampled on rising serial-clock edges, most significant bit first. Each group of four bytes forms one instruction. Its bytes appear on `cmd_op_o`, `cmd_addr_hi_o`, `cmd_addr_lo_o` and `cmd_data_o` in order of arrival.
- R2: Once the link is enabled, every complete instruction other than programming-enable gives exactly one `cmd_valid_o` pulse, one system clock wide. The four fields hold that instruction's bytes while the pulse is high.
- R3: An instruction whose first byte is 0xAC and whose second byte is 0x53 sets `prog_en_o`. Its third and fourth bytes can be anything, and it produces no valid pulse.
- R4: Until programming-enable has been accepted, no instruction produces a valid pulse and `prog_en_o` stays 0. This holds for every first-byte value, and also for 0xAC followed by a second byte other than 0x53.
- R5: `miso_o` changes only after falling serial-clock edges. The response to byte 0 is 0x00. The response to bytes 1 and 2 is the byte received just before. So 0x53 comes back while the third byte of programming-enable is being received.
- R6: Once the link is enabled, opcode 0x20 is a read. Its byte 3 response is `rd_data_i`, sampled at the first falling edge after byte 2 completes. By that time the address fields already hold bytes 1 and 2. Any other opcode, or any opcode before enable, echoes byte 2 as the byte 3 response.
- R7: Once the link is enabled, opcode 0xF0 is a status poll. Its byte 3 response is 0x00 with `busy_i` in bit 0.
- R8: While `tgt_rst_i` is high, the bit and byte counters are held at zero, serial-clock activity is ignored, `prog_en_o` is cleared and `miso_o` is 0. After release, framing starts again at byte 0 bit 0.
- R9: Stray serial-clock pulses shift the framing for good, so a following programming-enable is not recognised. Only a target reset pulse restores alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| tgt_rst_i | input | 1 | Target reset from host, active high, asynchronous |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| mosi_i | input | 1 | Serial data from host, asynchronous |
| miso_o | output | 1 | Serial response to host |
| rd_data_i | input | 8 | Memory byte for the address on the address fields |
| busy_i | input | 1 | Memory write in progress |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded instruction |
| cmd_op_o | output | 8 | Instruction byte 0 |
| cmd_addr_hi_o | output | 8 | Instruction byte 1 |
| cmd_addr_lo_o | output | 8 | Instruction byte 2 |
| cmd_data_o | output | 8 | Instruction byte 3 |
| prog_en_o | output | 1 | Programming enabled |

## Verification
The assertions assume that the serial clock stays high and stays low for several system clocks at a time. They also assume that the serial data is steady for at least two system clocks before each rising edge, so that each synchronised edge is seen once and picks up settled data. The bench holds every serial-clock phase for eight system clocks and changes data only while the clock is low. It pulses the target reset for four system clocks. It reads the response bit at the end of each low phase, which is well after the falling edge that updated it.

// File: rtl/psi_pkg.sv
package psi_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_BYTES = 4;
  localparam logic [BYTE_W-1:0] ENA_OP   = 8'hAC;
  localparam logic [BYTE_W-1:0] ENA_KEY  = 8'h53;
  localparam logic [BYTE_W-1:0] RD_OP    = 8'h20;
  localparam logic [BYTE_W-1:0] POLL_OP  = 8'hF0;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] dat;
  } instr_t;
endpackage

// File: rtl/psi_sync.sv
module psi_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/psi_shift.sv
module psi_shift #(
  parameter int BW = 8,
  parameter int NB = 4,
  localparam int CW  = $clog2(BW),
  localparam int BCW = $clog2(NB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           sck_i,
  input  logic           mosi_i,
  input  logic [BW-1:0]  resp_i,
  output logic [BW-1:0]  byte_o,
  output logic           done_o,
  output logic [BCW-1:0] idx_o,
  output logic           miso_o
);
  logic           sck_q;
  logic           rise, fall;
  logic [CW-1:0]  bit_cnt;
  logic [BCW-1:0] byte_cnt;
  logic [BW-2:0]  sh;
  logic [BW-1:0]  tx;
  logic           load_pend;
  logic           miso_q;

  assign rise   = sck_i & ~sck_q;
  assign fall   = ~sck_i & sck_q;
  assign done_o = rise && !clr_i && (bit_cnt == CW'(BW-1));
  assign byte_o = {sh, mosi_i};
  assign idx_o  = byte_cnt;
  assign miso_o = miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      sh        <= '0;
      tx        <= '0;
      load_pend <= 1'b0;
      miso_q    <= 1'b0;
    end else if (clr_i) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      sh        <= '0;
      tx        <= '0;
      load_pend <= 1'b0;
      miso_q    <= 1'b0;
    end else begin
      if (rise) begin
        sh <= byte_o[BW-2:0];
        if (bit_cnt == CW'(BW-1)) begin
          bit_cnt   <= '0;
          byte_cnt  <= (byte_cnt == BCW'(NB-1)) ? '0 : byte_cnt + 1'b1;
          load_pend <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (fall) begin
        if (load_pend) begin
          miso_q    <= resp_i[BW-1];
          tx        <= {resp_i[BW-2:0], 1'b0};
          load_pend <= 1'b0;
        end else begin
          miso_q <= tx[BW-1];
          tx     <= {tx[BW-2:0], 1'b0};
        end
      end
    end
  end

  // R8
  clr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bit_cnt == '0) && (byte_cnt == '0) && !miso_q);
  // R5
  miso_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && !clr_i) |=> $stable(miso_q));
  // R1
  bit_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && !clr_i) |=> $stable(bit_cnt) && $stable(byte_cnt));
endmodule

// File: rtl/psi_decode.sv
module psi_decode
  import psi_pkg::*;
#(
  localparam int NB  = NUM_BYTES,
  localparam int BW  = BYTE_W,
  localparam int BCW = $clog2(NB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           done_i,
  input  logic [BCW-1:0] idx_i,
  input  logic [BW-1:0]  byte_i,
  input  logic [BW-1:0]  rd_data_i,
  input  logic           busy_i,
  output instr_t         instr_o,
  output logic           valid_o,
  output logic           en_o,
  output logic [BW-1:0]  resp_o
);
  logic [BW-1:0] bq [NB];
  logic          en_q, valid_q;
  logic          is_ena;

  assign is_ena = (bq[0] == ENA_OP) && (bq[1] == ENA_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) bq[i] <= '0;
      en_q    <= 1'b0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      for (int i = 0; i < NB; i++) bq[i] <= '0;
      en_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (done_i) begin
        bq[idx_i] <= byte_i;
        if (idx_i == BCW'(NB-1)) begin
          if (is_ena)    en_q    <= 1'b1;
          else if (en_q) valid_q <= 1'b1;
        end
      end
    end
  end

  // idx_i points at the byte about to be shifted
  always_comb begin
    resp_o = '0;
    if (idx_i != '0) resp_o = bq[idx_i - 1'b1];
    if (idx_i == BCW'(NB-1) && en_q) begin
      if (bq[0] == RD_OP)        resp_o = rd_data_i;
      else if (bq[0] == POLL_OP) resp_o = {{(BW-1){1'b0}}, busy_i};
    end
  end

  assign instr_o = '{op: bq[0], hi: bq[1], lo: bq[2], dat: bq[3]};
  assign valid_o = valid_q;
  assign en_o    = en_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R4
  valid_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> en_q);
  // R3
  en_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(done_i && idx_i == BCW'(NB-1)));
endmodule

// File: rtl/prog_serial_if.sv
module prog_serial_if
  import psi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tgt_rst_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic [7:0] rd_data_i,
  input  logic       busy_i,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_op_o,
  output logic [7:0] cmd_addr_hi_o,
  output logic [7:0] cmd_addr_lo_o,
  output logic [7:0] cmd_data_o,
  output logic       prog_en_o
);
  localparam int BCW = $clog2(NUM_BYTES);

  logic [2:0]        sync_q;
  logic              clr, sck_s, mosi_s;
  logic [BYTE_W-1:0] rx_byte, resp;
  logic              done;
  logic [BCW-1:0]    idx;
  instr_t            instr;

  psi_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tgt_rst_i, mosi_i, sck_i}),
    .q_o   (sync_q)
  );
  assign {clr, mosi_s, sck_s} = sync_q;

  psi_shift #(.BW(BYTE_W), .NB(NUM_BYTES)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .sck_i (sck_s),
    .mosi_i(mosi_s),
    .resp_i(resp),
    .byte_o(rx_byte),
    .done_o(done),
    .idx_o (idx),
    .miso_o(miso_o)
  );

  psi_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .done_i   (done),
    .idx_i    (idx),
    .byte_i   (rx_byte),
    .rd_data_i(rd_data_i),
    .busy_i   (busy_i),
    .instr_o  (instr),
    .valid_o  (cmd_valid_o),
    .en_o     (prog_en_o),
    .resp_o   (resp)
  );

  assign cmd_op_o      = instr.op;
  assign cmd_addr_hi_o = instr.hi;
  assign cmd_addr_lo_o = instr.lo;
  assign cmd_data_o    = instr.dat;
endmodule

// File: tb/sim_prog_serial_if.sv
module sim_prog_serial_if;
  logic clk = 0, rst_ni = 0, tgt_rst = 0, sck = 0, mosi = 0, busy = 0;
  logic miso, cmd_valid, prog_en;
  logic [7:0] rd_data, op, ahi, alo, dat;
  int total = 0, bad = 0, vcnt = 0;
  logic [31:0] vcap;
  logic done_flag = 0;

  always #5 clk = ~clk;

  prog_serial_if u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tgt_rst_i(tgt_rst), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .rd_data_i(rd_data), .busy_i(busy), .cmd_valid_o(cmd_valid),
    .cmd_op_o(op), .cmd_addr_hi_o(ahi), .cmd_addr_lo_o(alo), .cmd_data_o(dat),
    .prog_en_o(prog_en)
  );

  // memory model: addressed byte
  assign rd_data = ahi ^ alo ^ 8'h5A;

  always @(posedge clk) if (cmd_valid) begin
    vcnt++;
    vcap = {op, ahi, alo, dat};
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic m);
    mosi = b;
    repeat (8) @(negedge clk);
    m = miso;
    sck = 1;
    repeat (8) @(negedge clk);
    sck = 0;
  endtask

  task automatic byte_x(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_x(t[i], r[i]);
  endtask

  task automatic instr(input logic [7:0] a, b, c, d, output logic [31:0] r);
    byte_x(a, r[31:24]);
    byte_x(b, r[23:16]);
    byte_x(c, r[15:8]);
    byte_x(d, r[7:0]);
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_rst();
    tgt_rst = 1;
    repeat (4) @(negedge clk);
    tgt_rst = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic m;
    int v0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    // R8 reset state
    check(miso == 0 && prog_en == 0 && vcnt == 0, "R8", {miso, prog_en}, 0);

    // R4 ignored before enable, R6 echo fallback
    for (int i = 0; i < 8; i++) begin
      logic [7:0] o;
      logic [7:0] k;
      o = (i == 0) ? 8'h20 : (i == 1) ? 8'hF0 : (i == 2) ? 8'hAC : 8'(i * 37);
      k = (i == 2) ? 8'h52 : 8'(i * 3 + 1);
      v0 = vcnt;
      instr(o, k, 8'(i + 100), 8'h11, r);
      check(vcnt == v0 && prog_en == 0, "R4", vcnt, v0);
      check(r[7:0] == 8'(i + 100), "R6", r[7:0], 8'(i + 100));
    end

    // R9 stray bit breaks framing until reset pulse
    pulse_rst();
    bit_x(1'b0, m);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check(prog_en == 0, "R9", prog_en, 0);
    pulse_rst();

    // R3 / R5 enable with echo
    v0 = vcnt;
    instr(8'hAC, 8'h53, 8'h12, 8'h34, r);
    check(prog_en == 1, "R3", prog_en, 1);
    check(vcnt == v0, "R3", vcnt, v0);
    check(r == 32'h00AC5312, "R5", r, 32'h00AC5312);

    // R1 / R2 write sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, b, c, d;
      a = 8'h40 + 8'(i); b = 8'(i * 13); c = ~8'(i * 7); d = 8'(i * 29 + 3);
      v0 = vcnt;
      instr(a, b, c, d, r);
      check(vcnt == v0 + 1, "R2", vcnt, v0 + 1);
      check(vcap == {a, b, c, d}, "R1", vcap, {a, b, c, d});
      check(r == {8'h00, a, b, c}, "R5", r, {8'h00, a, b, c});
    end

    // R6 read sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b, c;
      b = 8'(i * 11); c = 8'(i * 5 + 1);
      instr(8'h20, b, c, 8'hEE, r);
      check(r[7:0] == (b ^ c ^ 8'h5A), "R6", r[7:0], b ^ c ^ 8'h5A);
    end

    // R7 status poll
    for (int i = 0; i < 2; i++) begin
      busy = 1'(i);
      instr(8'hF0, 8'h00, 8'h00, 8'h00, r);
      check(r[7:0] == 8'(i), "R7", r[7:0], i);
    end
    busy = 0;

    // R8 partial byte then reset clears enable and framing
    for (int i = 0; i < 3; i++) bit_x(1'b1, m);
    pulse_rst();
    check(prog_en == 0 && miso == 0, "R8", {prog_en, miso}, 0);
    // R8 clock activity ignored while reset held
    tgt_rst = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) bit_x(1'b1, m);
    check(miso == 0, "R8", miso, 0);
    tgt_rst = 0;
    repeat (4) @(negedge clk);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check(prog_en == 1, "R8", prog_en, 1);
    v0 = vcnt;
    instr(8'h41, 8'h02, 8'h03, 8'h04, r);
    check(vcnt == v0 + 1 && vcap == 32'h41020304, "R8", vcap, 32'h41020304);

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule